// File: doc/BRIEF.md
# Sparse Super-Block Tag Lookup

This unit answers tag queries for a compressed cache that stores each super-block of eight adjacent 64-byte blocks in one or more data entries. An entry holds 1, 2, 4 or 8 adjacent blocks, according to the compression factor the blocks share. Each tag entry keeps the super-block address and one valid bit for each of the eight block positions. It keeps no pointers. The size of the blocks an entry holds is not stored either. It follows from the way the entry sits in and from two address bits, so a lookup has to probe every way, each at a set index of its own.

In lookup mode the unit tells whether the addressed block is present. On a hit it reports the hitting way, the compression factor implied by that way, and the byte offset of the block inside the 64-byte entry. In neighbour mode the caller supplies a compression factor. The unit then looks for an entry of that size that already holds a neighbour of the block and still has the block's own slot free. A new compressed block can be written into such an entry without evicting anything. The tag array is filled through a simple write port. Data storage and decompression are left to other blocks.

Top module: `sparse_sb_lookup`

## Requirements
- R1: After reset every entry is invalid, rsp_valid_o and hit_o are low, and a lookup of any address misses.
- R2: A request sampled while req_valid_i is high produces its result on the outputs one clock later, with rsp_valid_o high for exactly that cycle.
- R3: The address splits into block position blk = addr[8:6], group select sel = addr[10:9] and super-block tag addr[ADDR_W-1:9]. Way w belongs to group g = w / (NUM_WAYS/4) and has in-group index j = w % (NUM_WAYS/4). In lookup mode, way w holds blocks of compression factor cf = sel XOR g.
- R4: The set probed in way w for factor cf is fold(key) XOR fold(key >> (j+1)). Here key = {addr[ADDR_W-1:11], addr[8:6]} >> cf, and fold is the XOR of the key's SET_W-bit slices taken from the LSB, zero padded.
- R5: A lookup hits when a probed entry's stored tag equals addr[ADDR_W-1:9] and its valid bit at position blk is set. hit_way_o gives that way and cf_o gives the factor implied for it.
- R6: A probed entry whose tag matches but whose valid bit at position blk is clear does not produce a hit.
- R7: On a hit, offset_o = (blk mod 2^cf) << (6 - cf). This is 0 for cf 0, blk[0]*32 for cf 1, blk[1:0]*16 for cf 2 and blk*8 for cf 3.
- R8: In neighbour mode (mode_i = 1) only the ways of group sel XOR req_cf_i are probed, at the set for req_cf_i. A way hits when its tag matches, at least one valid bit is set in the aligned run of 2^req_cf_i positions containing blk, and the bit at blk itself is clear. cf_o then equals req_cf_i and offset_o follows R7.
- R9: A neighbour-mode request with req_cf_i = 0, or one whose own block position is already valid, reports no hit.
- R10: At most one way reports a hit for a consistently filled array. The group of hit_way_o equals sel XOR cf_o.
- R11: Whenever a response reports no hit, hit_way_o, cf_o and offset_o are zero.
- R12: When wr_en_i is high, the entry at (wr_way_i, wr_set_i) takes wr_tag_i and wr_state_i at that clock edge. Requests issued from the next cycle on see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Tag entry write strobe |
| wr_way_i | input | WAY_W | Way of the entry to write |
| wr_set_i | input | SET_W | Set of the entry to write |
| wr_tag_i | input | TAG_W | Super-block tag to store |
| wr_state_i | input | 8 | Per-position valid bits to store |
| req_valid_i | input | 1 | Request strobe |
| mode_i | input | 1 | 0 = block lookup, 1 = neighbour-space search |
| req_cf_i | input | 2 | Compression factor searched in neighbour mode |
| addr_i | input | ADDR_W | Block address of the request |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| hit_o | output | 1 | Hit (or room found, in neighbour mode) |
| hit_way_o | output | WAY_W | Hitting way |
| cf_o | output | 2 | Compression factor of the hit |
| offset_o | output | 6 | Byte offset of the block inside the entry |

## Verification
Entries are planted for all four compression factors in different groups and ways, at the set the hashing rule gives, and every block position is queried. Querying every position of a full eight-block entry separates offset errors from hashing and way errors. Partly filled entries separate the tag-only compare from the compare that also needs the valid bit. Neighbour-mode queries cover the following cases against the same entries:
- a free slot beside a valid neighbour,
- an already occupied slot,
- a factor that selects another group,
- factor zero.

Together these tell room detection apart from a plain hit. An overwrite followed at once by a query checks that writes take effect in the next cycle.

// File: rtl/sparse_sb_pkg.sv
package sparse_sb_pkg;
  localparam int BLK_NUM   = 8;
  localparam int BLK_W     = 3;
  localparam int BLK_LSB   = 6;
  localparam int SEL_LSB   = 9;
  localparam int UPPER_LSB = 11;
  localparam int OFF_W     = 6;

  typedef enum logic [1:0] {
    CF_FULL    = 2'd0,
    CF_HALF    = 2'd1,
    CF_QUARTER = 2'd2,
    CF_EIGHTH  = 2'd3
  } cf_e;

  function automatic logic [OFF_W-1:0] byte_offset(input logic [BLK_W-1:0] blk,
                                                   input logic [1:0] cf);
    case (cf)
      CF_HALF:    return {blk[0], 5'b0};
      CF_QUARTER: return {blk[1:0], 4'b0};
      CF_EIGHTH:  return {blk, 3'b0};
      default:    return '0;
    endcase
  endfunction

  // Aligned run of 2^cf positions that contains blk
  function automatic logic [BLK_NUM-1:0] chunk_mask(input logic [BLK_W-1:0] blk,
                                                    input logic [1:0] cf);
    logic [BLK_NUM-1:0] base;
    logic [BLK_W-1:0]   start;
    case (cf)
      CF_HALF:    base = 8'h03;
      CF_QUARTER: base = 8'h0f;
      CF_EIGHTH:  base = 8'hff;
      default:    base = 8'h01;
    endcase
    start = (blk >> cf) << cf;
    return base << start;
  endfunction
endpackage

// File: rtl/sparse_sb_tags.sv
module sparse_sb_tags #(
  parameter int NUM_WAYS = 16,
  parameter int SET_W    = 3,
  parameter int TAG_W    = 15,
  parameter int BLK_NUM  = 8,
  localparam int SETS    = 1 << SET_W,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [WAY_W-1:0]   wr_way_i,
  input  logic [SET_W-1:0]   wr_set_i,
  input  logic [TAG_W-1:0]   wr_tag_i,
  input  logic [BLK_NUM-1:0] wr_state_i,
  input  logic [SET_W-1:0]   rd_set_i   [NUM_WAYS],
  output logic [TAG_W-1:0]   rd_tag_o   [NUM_WAYS],
  output logic [BLK_NUM-1:0] rd_state_o [NUM_WAYS]
);
  logic [TAG_W-1:0]   tag_q   [NUM_WAYS][SETS];
  logic [BLK_NUM-1:0] state_q [NUM_WAYS][SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        for (int s = 0; s < SETS; s++) begin
          tag_q[w][s]   <= '0;
          state_q[w][s] <= '0;
        end
      end
    end else if (wr_en_i) begin
      tag_q[wr_way_i][wr_set_i]   <= wr_tag_i;
      state_q[wr_way_i][wr_set_i] <= wr_state_i;
    end
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
    assign rd_tag_o[w]   = tag_q[w][rd_set_i[w]];
    assign rd_state_o[w] = state_q[w][rd_set_i[w]];
  end
endmodule

// File: rtl/sparse_sb_map.sv
module sparse_sb_map
  import sparse_sb_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 3,
  parameter int J      = 0,
  localparam int KEY_W = ADDR_W - UPPER_LSB + BLK_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        cf_i,
  output logic [SET_W-1:0]  set_o
);
  logic [KEY_W-1:0] key;

  function automatic logic [SET_W-1:0] fold(input logic [KEY_W-1:0] k);
    logic [KEY_W-1:0] r;
    r = '0;
    for (int i = 0; i < KEY_W; i += SET_W) r ^= k >> i;
    return r[SET_W-1:0];
  endfunction

  // Block-ID bits shared by one entry drop out of the key
  assign key   = {addr_i[ADDR_W-1:UPPER_LSB], addr_i[BLK_LSB +: BLK_W]} >> cf_i;
  assign set_o = fold(key) ^ fold(key >> (J + 1));
endmodule

// File: rtl/sparse_sb_probe.sv
module sparse_sb_probe
  import sparse_sb_pkg::*;
#(
  parameter int TAG_W = 15
) (
  input  logic [TAG_W-1:0]   ent_tag_i,
  input  logic [BLK_NUM-1:0] ent_state_i,
  input  logic [TAG_W-1:0]   req_tag_i,
  input  logic [BLK_W-1:0]   blk_i,
  input  logic [1:0]         cf_i,
  output logic               match_o,
  output logic               room_o
);
  logic tag_eq, own_valid, nb_valid;

  assign tag_eq    = (ent_tag_i == req_tag_i);
  assign own_valid = ent_state_i[blk_i];
  // Occupied neighbours imply the block-ID bits that are not stored
  assign nb_valid  = |(ent_state_i & chunk_mask(blk_i, cf_i));
  assign match_o   = tag_eq & own_valid;
  assign room_o    = tag_eq & nb_valid & ~own_valid;
endmodule

// File: rtl/sparse_sb_lookup.sv
module sparse_sb_lookup
  import sparse_sb_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int NUM_WAYS = 16,
  parameter int SET_W    = 3,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int TAG_W   = ADDR_W - SEL_LSB,
  localparam int WPG     = NUM_WAYS / 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [WAY_W-1:0]   wr_way_i,
  input  logic [SET_W-1:0]   wr_set_i,
  input  logic [TAG_W-1:0]   wr_tag_i,
  input  logic [BLK_NUM-1:0] wr_state_i,
  input  logic               req_valid_i,
  input  logic               mode_i,
  input  logic [1:0]         req_cf_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               rsp_valid_o,
  output logic               hit_o,
  output logic [WAY_W-1:0]   hit_way_o,
  output logic [1:0]         cf_o,
  output logic [OFF_W-1:0]   offset_o
);
  logic [BLK_W-1:0]   blk;
  logic [1:0]         sel;
  logic [TAG_W-1:0]   req_tag;
  logic [SET_W-1:0]   way_set   [NUM_WAYS];
  logic [TAG_W-1:0]   way_tag   [NUM_WAYS];
  logic [BLK_NUM-1:0] way_state [NUM_WAYS];
  logic [1:0]         way_cf    [NUM_WAYS];
  logic [NUM_WAYS-1:0] hit_vec;

  assign blk     = addr_i[BLK_LSB +: BLK_W];
  assign sel     = addr_i[SEL_LSB +: 2];
  assign req_tag = addr_i[ADDR_W-1:SEL_LSB];

  sparse_sb_tags #(
    .NUM_WAYS(NUM_WAYS), .SET_W(SET_W), .TAG_W(TAG_W), .BLK_NUM(BLK_NUM)
  ) u_tags (
    .clk_i, .rst_ni, .wr_en_i, .wr_way_i, .wr_set_i, .wr_tag_i, .wr_state_i,
    .rd_set_i(way_set), .rd_tag_o(way_tag), .rd_state_o(way_state)
  );

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    localparam int G = w / WPG;
    localparam int J = w % WPG;
    logic implied_ok, match, room;

    assign implied_ok = ((sel ^ 2'(G)) == req_cf_i);
    assign way_cf[w]  = mode_i ? req_cf_i : (sel ^ 2'(G));

    sparse_sb_map #(.ADDR_W(ADDR_W), .SET_W(SET_W), .J(J)) u_map (
      .addr_i, .cf_i(way_cf[w]), .set_o(way_set[w])
    );

    sparse_sb_probe #(.TAG_W(TAG_W)) u_probe (
      .ent_tag_i(way_tag[w]), .ent_state_i(way_state[w]), .req_tag_i(req_tag),
      .blk_i(blk), .cf_i(way_cf[w]), .match_o(match), .room_o(room)
    );

    assign hit_vec[w] = mode_i ? (room & implied_ok) : match;
  end

  logic             hit_any;
  logic [WAY_W-1:0] hit_idx;
  logic [1:0]       hit_cf;

  always_comb begin
    hit_any = |hit_vec;
    hit_idx = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_idx = WAY_W'(w);
    end
    hit_cf = way_cf[hit_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      hit_way_o   <= '0;
      cf_o        <= '0;
      offset_o    <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      hit_o       <= req_valid_i & hit_any;
      if (req_valid_i && hit_any) begin
        hit_way_o <= hit_idx;
        cf_o      <= hit_cf;
        offset_o  <= byte_offset(blk, hit_cf);
      end else begin
        hit_way_o <= '0;
        cf_o      <= '0;
        offset_o  <= '0;
      end
    end
  end
endmodule

// File: rtl/sparse_sb_lookup_chk.sv
module sparse_sb_lookup_chk #(
  parameter int ADDR_W   = 24,
  parameter int NUM_WAYS = 16,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int WPG     = NUM_WAYS / 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                mode_i,
  input logic [1:0]          req_cf_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                rsp_valid_o,
  input logic                hit_o,
  input logic [WAY_W-1:0]    hit_way_o,
  input logic [1:0]          cf_o,
  input logic [5:0]          offset_o,
  input logic [NUM_WAYS-1:0] hit_vec
);
  a_r2_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r2_rsp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  a_r1_hit_in_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> rsp_valid_o);

  a_r10_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $onehot0(hit_vec));

  a_r10_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (!hit_o || (2'(hit_way_o / WAY_W'(WPG)) == ($past(addr_i[10:9]) ^ cf_o))));

  a_r11_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !hit_o) |-> (hit_way_o == '0 && cf_o == 2'd0 && offset_o == 6'd0));

  a_r7_offset_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((offset_o & 6'((7'd64 >> cf_o) - 7'd1)) == 6'd0));

  a_r8_nb_cf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i) |=> (!hit_o || cf_o == $past(req_cf_i)));

  a_r9_nb_cf0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i && req_cf_i == 2'd0) |=> !hit_o);
endmodule

bind sparse_sb_lookup sparse_sb_lookup_chk #(.ADDR_W(ADDR_W), .NUM_WAYS(NUM_WAYS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .mode_i(mode_i),
  .req_cf_i(req_cf_i), .addr_i(addr_i), .rsp_valid_o(rsp_valid_o), .hit_o(hit_o),
  .hit_way_o(hit_way_o), .cf_o(cf_o), .offset_o(offset_o), .hit_vec(hit_vec)
);

// File: tb/sparse_sb_lookup_test.sv
module sparse_sb_lookup_test;
  localparam int ADDR_W = 24;
  localparam int NW     = 16;
  localparam int SET_W  = 3;
  localparam int TAG_W  = ADDR_W - 9;
  localparam int WPG    = NW / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_way = '0;
  logic [SET_W-1:0] wr_set = '0;
  logic [TAG_W-1:0] wr_tag = '0;
  logic [7:0] wr_state = '0;
  logic req_valid = 1'b0;
  logic mode = 1'b0;
  logic [1:0] req_cf = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic rsp_valid, hit;
  logic [3:0] hit_way;
  logic [1:0] cf;
  logic [5:0] offset;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  sparse_sb_lookup uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_way_i(wr_way), .wr_set_i(wr_set),
    .wr_tag_i(wr_tag), .wr_state_i(wr_state), .req_valid_i(req_valid), .mode_i(mode),
    .req_cf_i(req_cf), .addr_i(addr), .rsp_valid_o(rsp_valid), .hit_o(hit),
    .hit_way_o(hit_way), .cf_o(cf), .offset_o(offset)
  );

  function automatic logic [ADDR_W-1:0] mk(input logic [12:0] top, input logic [1:0] sel,
                                           input logic [2:0] blk);
    return {top, sel, blk, 6'h0};
  endfunction

  function automatic logic [2:0] fold3(input logic [15:0] k);
    logic [15:0] r = '0;
    for (int i = 0; i < 16; i += 3) r ^= k >> i;
    return r[2:0];
  endfunction

  // R4 set rule
  function automatic logic [2:0] exp_set(input int j, input logic [1:0] c, input logic [ADDR_W-1:0] a);
    logic [15:0] key = {a[23:11], a[8:6]} >> c;
    return fold3(key) ^ fold3(key >> (j + 1));
  endfunction

  // R3 placement: group = sel ^ cf
  function automatic logic [3:0] exp_way(input int j, input logic [1:0] c, input logic [ADDR_W-1:0] a);
    return 4'((int'(a[10:9] ^ c)) * WPG + j);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic place(input logic [ADDR_W-1:0] a, input logic [1:0] c, input int j, input logic [7:0] st);
    @(negedge clk);
    wr_en = 1'b1; wr_way = exp_way(j, c, a); wr_set = exp_set(j, c, a);
    wr_tag = a[23:9]; wr_state = st;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one request; result sampled at the negedge after the capturing edge
  task automatic query(input logic m, input logic [1:0] c, input logic [ADDR_W-1:0] a,
                       input bit e_hit, input logic [3:0] e_way, input logic [1:0] e_cf,
                       input logic [5:0] e_off, input string req);
    @(negedge clk);
    req_valid = 1'b1; mode = m; req_cf = c; addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, "R2", "rsp_valid", int'(rsp_valid), 1);
    check(hit == e_hit, req, "hit", int'(hit), int'(e_hit));
    check(hit_way == (e_hit ? e_way : 4'd0), e_hit ? req : "R11", "way", int'(hit_way), int'(e_hit ? e_way : 4'd0));
    check(cf == (e_hit ? e_cf : 2'd0), e_hit ? req : "R11", "cf", int'(cf), int'(e_hit ? e_cf : 2'd0));
    check(offset == (e_hit ? e_off : 6'd0), e_hit ? "R7" : "R11", "offset", int'(offset), int'(e_hit ? e_off : 6'd0));
    if (hit) check(2'(hit_way / WPG) == (a[10:9] ^ cf), "R10", "group", int'(hit_way / WPG), int'(a[10:9] ^ cf));
    @(negedge clk);
    check(rsp_valid == 1'b0, "R2", "rsp_valid after", int'(rsp_valid), 0);
  endtask

  task automatic t_reset;
    check(rsp_valid == 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
    check(hit == 1'b0, "R1", "hit", int'(hit), 0);
    query(1'b0, 2'd0, mk(13'h0123, 2'd2, 3'd4), 1'b0, 4'd0, 2'd0, 6'd0, "R1");
  endtask

  task automatic t_full_eighth;
    logic [ADDR_W-1:0] a = mk(13'h0123, 2'd2, 3'd0);
    place(a, 2'd3, 2, 8'hff);
    for (int b = 0; b < 8; b++)
      query(1'b0, 2'd0, mk(13'h0123, 2'd2, 3'(b)), 1'b1, exp_way(2, 2'd3, a), 2'd3, 6'(b * 8), "R5");
  endtask

  task automatic t_state_miss;
    logic [ADDR_W-1:0] a = mk(13'h0456, 2'd0, 3'd0);
    place(a, 2'd3, 0, 8'h05);
    query(1'b0, 2'd0, mk(13'h0456, 2'd0, 3'd1), 1'b0, 4'd0, 2'd0, 6'd0, "R6");
    query(1'b0, 2'd0, mk(13'h0456, 2'd0, 3'd2), 1'b1, exp_way(0, 2'd3, a), 2'd3, 6'd16, "R6");
  endtask

  task automatic t_half_quarter_full;
    logic [ADDR_W-1:0] a1 = mk(13'h0789, 2'd1, 3'd6);
    logic [ADDR_W-1:0] a2 = mk(13'h0abc, 2'd3, 3'd5);
    logic [ADDR_W-1:0] a0 = mk(13'h0def, 2'd0, 3'd5);
    place(a1, 2'd1, 1, 8'hc0);
    place(a2, 2'd2, 3, 8'h60);
    place(a0, 2'd0, 0, 8'h20);
    query(1'b0, 2'd0, mk(13'h0789, 2'd1, 3'd7), 1'b1, exp_way(1, 2'd1, a1), 2'd1, 6'd32, "R3");
    query(1'b0, 2'd0, mk(13'h0789, 2'd1, 3'd6), 1'b1, exp_way(1, 2'd1, a1), 2'd1, 6'd0, "R4");
    query(1'b0, 2'd0, mk(13'h0abc, 2'd3, 3'd5), 1'b1, exp_way(3, 2'd2, a2), 2'd2, 6'd16, "R7");
    query(1'b0, 2'd0, mk(13'h0abc, 2'd3, 3'd6), 1'b1, exp_way(3, 2'd2, a2), 2'd2, 6'd32, "R7");
    query(1'b0, 2'd0, a0, 1'b1, exp_way(0, 2'd0, a0), 2'd0, 6'd0, "R5");
  endtask

  task automatic t_neighbour;
    logic [ADDR_W-1:0] an = mk(13'h1111, 2'd1, 3'd4);
    place(an, 2'd2, 2, 8'h10);
    query(1'b1, 2'd2, mk(13'h1111, 2'd1, 3'd6), 1'b1, exp_way(2, 2'd2, an), 2'd2, 6'd32, "R8");
    query(1'b1, 2'd2, mk(13'h1111, 2'd1, 3'd4), 1'b0, 4'd0, 2'd0, 6'd0, "R9");
    query(1'b1, 2'd1, mk(13'h1111, 2'd1, 3'd5), 1'b0, 4'd0, 2'd0, 6'd0, "R8");
    query(1'b0, 2'd0, mk(13'h1111, 2'd1, 3'd6), 1'b0, 4'd0, 2'd0, 6'd0, "R8");
    query(1'b1, 2'd3, mk(13'h0456, 2'd0, 3'd1), 1'b1, exp_way(0, 2'd3, mk(13'h0456, 2'd0, 3'd0)), 2'd3, 6'd8, "R8");
    query(1'b1, 2'd0, mk(13'h0def, 2'd0, 3'd5), 1'b0, 4'd0, 2'd0, 6'd0, "R9");
    query(1'b1, 2'd0, mk(13'h0def, 2'd0, 3'd4), 1'b0, 4'd0, 2'd0, 6'd0, "R9");
  endtask

  task automatic t_overwrite;
    logic [ADDR_W-1:0] a1 = mk(13'h0789, 2'd1, 3'd6);
    place(a1, 2'd1, 1, 8'h00);
    query(1'b0, 2'd0, mk(13'h0789, 2'd1, 3'd7), 1'b0, 4'd0, 2'd0, 6'd0, "R12");
    place(a1, 2'd1, 1, 8'h80);
    query(1'b0, 2'd0, mk(13'h0789, 2'd1, 3'd7), 1'b1, exp_way(1, 2'd1, a1), 2'd1, 6'd32, "R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_eighth();
    t_state_miss();
    t_half_quarter_full();
    t_neighbour();
    t_overwrite();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule